// File: doc/BRIEF.md
# Paged Instruction Address Unit with Circular Return Stack

This block produces the instruction address for a small 8-bit-style processor core. It holds a 13-bit program counter. Each cycle the counter either moves on by one or is redirected by a control event from the decoder. The decoder supplies a 3-bit event code, an 11-bit jump immediate and an 8-bit data byte that is used when software writes the low address byte. The upper address bits are never written directly. They come from a separate 5-bit page latch. A write of the low byte takes all five latch bits, while a jump or call takes only the top two latch bits.

An eight-deep return stack, 13 bits per entry, is built in. A call and an interrupt branch both push the address of the next sequential instruction. The three return events pop the top entry back into the counter. The stack pointer is hidden from software and wraps in both directions, so an overflow silently overwrites the oldest entry and an underflow returns whatever the wrapped slot holds. The block exposes the current address, a readback copy of its low byte and the page latch contents.

Top module: `iaddr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the page latch, every stack entry and the hidden pointer all clear to zero. The first cycle after reset shows `pc_o` = 0 and `page_o` = 0.
- R2: With event code 0 (sequential), `pc_o` becomes the old value plus one one cycle later, wrapping from 0x1FFF to 0x0000.
- R3: With event code 1 (low-byte write), `pc_o` becomes {page latch[4:0], `pcl_data_i`} on the next cycle. The latch value used is the one held before any latch write in that same cycle.
- R4: With event code 2 (call) or 3 (jump), `pc_o` becomes {page latch[4:3], `imm_i`} on the next cycle.
- R5: Event code 2 pushes the old `pc_o` plus one. Event codes 5, 6 and 7 (the three return forms, which behave identically) each pop the most recent entry into `pc_o` on the next cycle, in last-in-first-out order.
- R6: Event code 4 (interrupt branch) loads `pc_o` with 0x004 on the next cycle and pushes the old `pc_o` plus one.
- R7: The stack is circular over eight entries. After nine pushes, eight pops return the ninth down to the second pushed value, and a further pop returns the ninth value again.
- R8: A pop with no prior push after reset raises no flag. It wraps the pointer and loads the wrapped entry, which is 0 right after reset.
- R9: When `page_we_i` is high, the page latch takes `page_data_i` on the next cycle. No push, pop, jump or low-byte write ever changes the latch.
- R10: `pcl_o` always equals `pc_o[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Event code: 0 seq, 1 low-byte write, 2 call, 3 jump, 4 interrupt branch, 5/6/7 return forms |
| imm_i | input | 11 | Jump/call immediate address |
| pcl_data_i | input | 8 | Data byte for a low-byte write |
| page_we_i | input | 1 | Page latch write enable |
| page_data_i | input | 5 | Page latch write data |
| pc_o | output | 13 | Current instruction address |
| pcl_o | output | 8 | Readback of the address low byte |
| page_o | output | 5 | Current page latch contents |

## Verification
Every event code takes effect at the clock edge where it is sampled, and its result shows on `pc_o` one cycle later. The bench drives inputs on the falling edge and compares at the next falling edge, so each comparison falls after exactly one register stage. A page latch write also appears on `page_o` one cycle later, and a low-byte write issued in that same cycle still sees the old latch value. A return shows a pushed address two or more cycles after its call, so the stack tests compare against addresses recorded at push time rather than against a fixed delay.

// File: rtl/iaddr_pkg.sv
// Package: shared widths and the event code type for the instruction
// address unit. Assumes the decoder presents exactly one event per cycle.
package iaddr_pkg;
    localparam int PC_W  = 13;
    localparam int LO_W  = 8;
    localparam int IMM_W = 11;
    localparam int HI_W  = PC_W - LO_W;

    typedef enum logic [2:0] {
        EV_SEQ    = 3'd0,
        EV_PCLWR  = 3'd1,
        EV_CALL   = 3'd2,
        EV_GOTO   = 3'd3,
        EV_VEC    = 3'd4,
        EV_RET    = 3'd5,
        EV_RETLW  = 3'd6,
        EV_RETFIE = 3'd7
    } ev_e;
endpackage

// File: rtl/iaddr_page_latch.sv
// Module: page latch holding the upper address bits used by redirects.
// Assumes writes come only through the explicit enable; nothing else
// in the unit may modify it.
module iaddr_page_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture new page bits on an explicit write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/iaddr_retstack.sv
// Module: circular return stack with a hidden wrapping pointer.
// Assumes DEPTH is a power of two and that push and pop are never
// requested in the same cycle. The top-of-stack read is combinational.
module iaddr_retstack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] ptr;
    logic [AW-1:0] ptr_dec;
    logic [W-1:0]  slot [DEPTH];

    assign ptr_dec  = ptr - AW'(1);
    assign top_data = slot[ptr_dec];

    // Move the pointer up on push, down on pop; wraps in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (push) ptr <= ptr + AW'(1);
        else if (pop)  ptr <= ptr_dec;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Each slot takes the pushed address when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (push && (ptr == AW'(i)))
                slot[i] <= push_data;
        end
    end
endmodule

// File: rtl/iaddr_nextsel.sv
// Module: next-address selector. Purely combinational: decodes the event,
// forms the redirect address and raises the stack push/pop strobes.
// Assumes the latch and stack top are valid for the current cycle.
module iaddr_nextsel
    import iaddr_pkg::*;
#(
    parameter int           PW   = 13,
    parameter int           LW   = 8,
    parameter int           IW   = 11,
    parameter logic [PW-1:0] VEC = 13'h004
) (
    input  ev_e             ev,
    input  logic [PW-1:0]   pc,
    input  logic [PW-LW-1:0] page,
    input  logic [IW-1:0]   imm,
    input  logic [LW-1:0]   lo_data,
    input  logic [PW-1:0]   stack_top,
    output logic [PW-1:0]   nxt,
    output logic [PW-1:0]   ret_addr,
    output logic            push,
    output logic            pop
);
    localparam int HW = PW - LW;
    localparam int JW = PW - IW;

    logic [PW-1:0] jump_addr;

    assign ret_addr  = pc + PW'(1);
    assign jump_addr = {page[HW-1 -: JW], imm};

    // Select the next address and stack action for this event.
    always_comb begin
        nxt  = ret_addr;
        push = 1'b0;
        pop  = 1'b0;
        unique case (ev)
            EV_SEQ:    nxt = ret_addr;
            EV_PCLWR:  nxt = {page, lo_data};
            EV_CALL:   begin nxt = jump_addr; push = 1'b1; end
            EV_GOTO:   nxt = jump_addr;
            EV_VEC:    begin nxt = VEC; push = 1'b1; end
            EV_RET,
            EV_RETLW,
            EV_RETFIE: begin nxt = stack_top; pop = 1'b1; end
            default:   nxt = ret_addr;
        endcase
    end
endmodule

// File: rtl/iaddr_unit.sv
// Module: instruction address unit top. Holds the program counter, the
// page latch and the return stack; one event is applied per cycle.
// Assumes a synchronous active-low reset and a single clock domain.
module iaddr_unit
    import iaddr_pkg::*;
#(
    parameter int PC_BITS   = 13,
    parameter int LO_BITS   = 8,
    parameter int IMM_BITS  = 11,
    parameter int STK_DEPTH = 8,
    parameter logic [PC_BITS-1:0] VEC_ADDR = 13'h004
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    op_i,
    input  logic [IMM_BITS-1:0]           imm_i,
    input  logic [LO_BITS-1:0]            pcl_data_i,
    input  logic                          page_we_i,
    input  logic [PC_BITS-LO_BITS-1:0]    page_data_i,
    output logic [PC_BITS-1:0]            pc_o,
    output logic [LO_BITS-1:0]            pcl_o,
    output logic [PC_BITS-LO_BITS-1:0]    page_o
);
    localparam int HB = PC_BITS - LO_BITS;

    logic [PC_BITS-1:0] pc_q;
    logic [PC_BITS-1:0] pc_nxt;
    logic [PC_BITS-1:0] ret_addr;
    logic [PC_BITS-1:0] stack_top;
    logic [HB-1:0]      page_q;
    logic               do_push;
    logic               do_pop;
    ev_e                ev;

    assign ev = ev_e'(op_i);

    iaddr_page_latch #(.W(HB)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we_i),
        .d     (page_data_i),
        .q     (page_q)
    );

    iaddr_nextsel #(
        .PW  (PC_BITS),
        .LW  (LO_BITS),
        .IW  (IMM_BITS),
        .VEC (VEC_ADDR)
    ) u_sel (
        .ev        (ev),
        .pc        (pc_q),
        .page      (page_q),
        .imm       (imm_i),
        .lo_data   (pcl_data_i),
        .stack_top (stack_top),
        .nxt       (pc_nxt),
        .ret_addr  (ret_addr),
        .push      (do_push),
        .pop       (do_pop)
    );

    iaddr_retstack #(.W(PC_BITS), .DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (ret_addr),
        .top_data  (stack_top)
    );

    // Program counter register: clears on reset, else takes the selection.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign pc_o   = pc_q;
    assign pcl_o  = pc_q[LO_BITS-1:0];
    assign page_o = page_q;
endmodule

// File: rtl/iaddr_unit_chk.sv
// Module: property checker for the instruction address unit, bound to
// every instance of the top. Observes ports only.
module iaddr_unit_chk #(
    parameter int PC_BITS  = 13,
    parameter int LO_BITS  = 8,
    parameter int IMM_BITS = 11
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 op_i,
    input logic [IMM_BITS-1:0]        imm_i,
    input logic [LO_BITS-1:0]         pcl_data_i,
    input logic                       page_we_i,
    input logic [PC_BITS-1:0]         pc_o,
    input logic [PC_BITS-LO_BITS-1:0] page_o
);
    localparam int HB = PC_BITS - LO_BITS;
    localparam int JW = PC_BITS - IMM_BITS;

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_o == '0) && (page_o == '0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0) |=> pc_o == PC_BITS'($past(pc_o) + PC_BITS'(1)));

    p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> pc_o == {$past(page_o), $past(pcl_data_i)});

    p_jump_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 || op_i == 3'd3) |=>
            pc_o == {$past(page_o[HB-1 -: JW]), $past(imm_i)});

    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> pc_o == PC_BITS'(4));

    p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !page_we_i |=> $stable(page_o));
endmodule

bind iaddr_unit iaddr_unit_chk #(
    .PC_BITS  (PC_BITS),
    .LO_BITS  (LO_BITS),
    .IMM_BITS (IMM_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .imm_i      (imm_i),
    .pcl_data_i (pcl_data_i),
    .page_we_i  (page_we_i),
    .pc_o       (pc_o),
    .page_o     (page_o)
);

// File: tb/iaddr_unit_test.sv
`timescale 1ns/1ps
module iaddr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [10:0] imm;
    logic [7:0]  wd;
    logic        lwe;
    logic [4:0]  ld;
    logic [12:0] pc;
    logic [7:0]  pcl;
    logic [4:0]  page;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int mpc, mlatch, mptr;
    int mstk [8];
    int pushed [$];

    always #2 clk = ~clk;

    iaddr_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .imm_i(imm), .pcl_data_i(wd),
        .page_we_i(lwe), .page_data_i(ld), .pc_o(pc), .pcl_o(pcl), .page_o(page)
    );

    // Reference model updated on every rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            mpc = 0; mlatch = 0; mptr = 0;
            for (int i = 0; i < 8; i++) mstk[i] = 0;
        end else begin
            int nx;
            nx = (mpc + 1) % 8192;
            case (op)
                3'd0: mpc = nx;
                3'd1: mpc = mlatch * 256 + int'(wd);
                3'd2: begin mstk[mptr] = nx; mptr = (mptr + 1) % 8;
                            mpc = (mlatch / 8) * 2048 + int'(imm); end
                3'd3: mpc = (mlatch / 8) * 2048 + int'(imm);
                3'd4: begin mstk[mptr] = nx; mptr = (mptr + 1) % 8; mpc = 4; end
                default: begin mptr = (mptr + 7) % 8; mpc = mstk[mptr]; end
            endcase
            if (lwe) mlatch = int'(ld);
        end
    end

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, int'(pc), mpc);
        chk("R10", int'(pcl), mpc % 256);
        chk("R9", int'(page), mlatch);
    endtask

    task automatic step(logic [2:0] o, logic [10:0] i, logic [7:0] d,
                        logic we, logic [4:0] l);
        op = o; imm = i; wd = d; lwe = we; ld = l;
        @(posedge clk);
        @(negedge clk);
        compare(tag_of(o));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op = 3'd0; imm = '0; wd = '0; lwe = 1'b0; ld = '0;
        repeat (3) @(negedge clk);
        compare("R1");
        chk("R1", int'(pc), 0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: plain sequencing
        repeat (3) step(3'd0, '0, '0, 1'b0, '0);
        chk("R2", int'(pc), 3);
        // R9: latch write, visible next cycle
        step(3'd0, '0, '0, 1'b1, 5'h16);
        chk("R9", int'(page), 5'h16);
        // R3: low-byte write using old latch while latch is rewritten
        step(3'd1, '0, 8'h3C, 1'b1, 5'h01);
        chk("R3", int'(pc), 13'h163C);
        chk("R9", int'(page), 5'h01);
        step(3'd0, '0, '0, 1'b1, 5'h16);
        // R4: jump takes latch[4:3]
        step(3'd3, 11'h5A5, '0, 1'b0, '0);
        chk("R4", int'(pc), 13'h15A5);
        // R5/R6: call, interrupt branch, returns
        step(3'd2, 11'h123, '0, 1'b0, '0);
        chk("R4", int'(pc), 13'h1123);
        step(3'd0, '0, '0, 1'b0, '0);
        step(3'd4, '0, '0, 1'b0, '0);
        chk("R6", int'(pc), 13'h004);
        step(3'd7, '0, '0, 1'b0, '0);
        chk("R5", int'(pc), 13'h1125);
        step(3'd5, '0, '0, 1'b0, '0);
        chk("R5", int'(pc), 13'h15A6);
        chk("R9", int'(page), 5'h16);
        // R7: nine pushes then ten pops
        pushed.delete();
        for (int k = 0; k < 9; k++) begin
            pushed.push_back((int'(pc) + 1) % 8192);
            step(3'd2, 11'(k * 16 + 1), '0, 1'b0, '0);
        end
        for (int j = 0; j < 8; j++) begin
            step(3'd6, '0, '0, 1'b0, '0);
            chk("R7", int'(pc), pushed[8 - j]);
        end
        step(3'd6, '0, '0, 1'b0, '0);
        chk("R7", int'(pc), pushed[8]);
        // R8: pop right after reset
        do_reset();
        step(3'd5, '0, '0, 1'b0, '0);
        chk("R8", int'(pc), 0);
        step(3'd0, '0, '0, 1'b0, '0);
        chk("R8", int'(pc), 1);
        // R2: wrap at the top of the address space
        step(3'd0, '0, '0, 1'b1, 5'h1F);
        step(3'd1, '0, 8'hFF, 1'b0, '0);
        chk("R3", int'(pc), 13'h1FFF);
        step(3'd0, '0, '0, 1'b0, '0);
        chk("R2", int'(pc), 0);
        // mixed traffic against the reference model
        for (int n = 0; n < 400; n++) begin
            step(3'($urandom_range(0, 7)), 11'($urandom), 8'($urandom),
                 1'($urandom_range(0, 3) == 0), 5'($urandom));
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule